// File: doc/BRIEF.md
# Condition Code Flag Generator

This block derives the negative, zero, overflow and carry flags for an 8-bit or 16-bit add, subtract, test or shift step, and holds them in an 8-bit condition code register together with four control bits. The datapath that produces the result is outside the block. The block receives the two operands, the result the datapath formed, the operation class and the width. It then updates the flags one clock later.

Carry and overflow come from the sign bits of the operands and the result, not from an internal carry chain. For shifts the carry is the bit the shifter pushed out, and overflow is the new negative flag XOR that carry. Any single bit of the register can also be written directly, for instance to clear or set a control bit.

Top module: `ccr_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, `ccr_q` reads 0xD0. The bit map is bit 7 = S, bit 6 = X, bit 5 = H, bit 4 = I, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C, so S, X and I are set and all other bits are clear.
- R2: In a cycle with `upd_en` and `wr_en` both low, `ccr_q` keeps its value across the next clock edge.
- R3: On an update, N takes the result MSB at the selected width: bit 7 when `size_wide` = 0, bit 15 when `size_wide` = 1. Result bits above bit 7 have no effect in 8-bit mode.
- R4: On an update, Z is set exactly when the result at the selected width is zero. The upper byte is ignored in 8-bit mode.
- R5: For `op_class` = 0 (add), C is the MSB of (a&b)|(b&~r)|(a&~r) at the selected width.
- R6: For add, V is the MSB of (a&b&~r)|(~a&~b&r).
- R7: For `op_class` = 1 (subtract), C is the MSB of (~a&b)|(b&r)|(~a&r).
- R8: For subtract, V is the MSB of (a&~b&~r)|(~a&b&r).
- R9: For `op_class` = 2 (test), V is cleared and C keeps its previous value.
- R10: For `op_class` = 3 (shift), C takes `shift_c`, and V becomes the new N XOR `shift_c`.
- R11: A flag update never changes bits S, X, H or I.
- R12: With `wr_en` high, the bit whose index is `wr_sel` (using the R1 map) takes `wr_val` at the next edge. With `upd_en` low, every other bit keeps its value.
- R13: If `wr_en` and `upd_en` are both high, the written bit takes `wr_val` and the remaining flags follow the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Apply the flag update for this operation |
| op_class | input | 2 | 0 add, 1 subtract, 2 test, 3 shift |
| size_wide | input | 1 | 0 selects 8-bit, 1 selects 16-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result_r | input | 16 | Result produced by the datapath |
| shift_c | input | 1 | Bit shifted out by the shifter |
| wr_en | input | 1 | Direct single-bit write |
| wr_sel | input | 3 | Index of the bit to write |
| wr_val | input | 1 | Value to write |
| ccr_q | output | 8 | Condition code register |

## Verification
Every result of this block appears on `ccr_q` one clock edge after the inputs that cause it. No path from the inputs to `ccr_q` is combinational. The driver sets the inputs on the falling edge and queues one expected register value per cycle, including idle cycles. The monitor pops that value one nanosecond after the next rising edge, so each comparison sits in the cycle the register has just loaded and can never pick up the following stimulus.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   localparam int CCR_W = 8;
   localparam int SEL_W = $clog2(CCR_W);

   // bit positions inside the register
   localparam int B_S = 7;
   localparam int B_X = 6;
   localparam int B_H = 5;
   localparam int B_I = 4;
   localparam int B_N = 3;
   localparam int B_Z = 2;
   localparam int B_V = 1;
   localparam int B_C = 0;

   localparam logic [CCR_W-1:0] CCR_RESET =
      CCR_W'((1 << B_S) | (1 << B_X) | (1 << B_I));

   typedef enum logic [1:0] {
      OP_ADD   = 2'd0,
      OP_SUB   = 2'd1,
      OP_TEST  = 2'd2,
      OP_SHIFT = 2'd3
   } ccr_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic add_c;
      logic add_v;
      logic sub_c;
      logic sub_v;
   } width_flags_t;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } nzvc_t;

endpackage

// File: rtl/ccr_width_flags.sv
module ccr_width_flags #(
   parameter int W = 8
) (
   input  logic [W-1:0]           a,
   input  logic [W-1:0]           b,
   input  logic [W-1:0]           r,
   output ccr_pkg::width_flags_t  flags
);
   localparam int MSB = W - 1;

   logic [W-1:0] add_c_vec, add_v_vec, sub_c_vec, sub_v_vec;

   always_comb begin
      add_c_vec = (a & b) | (b & ~r) | (a & ~r);
      add_v_vec = (a & b & ~r) | (~a & ~b & r);
      sub_c_vec = (~a & b) | (b & r) | (~a & r);
      sub_v_vec = (a & ~b & ~r) | (~a & b & r);
      flags.n     = r[MSB];
      flags.z     = (r == '0);
      flags.add_c = add_c_vec[MSB];
      flags.add_v = add_v_vec[MSB];
      flags.sub_c = sub_c_vec[MSB];
      flags.sub_v = sub_v_vec[MSB];
   end

endmodule

// File: rtl/ccr_flag_merge.sv
module ccr_flag_merge (
   input  ccr_pkg::ccr_op_e      op,
   input  ccr_pkg::width_flags_t wf,
   input  logic                  shift_c,
   input  logic                  cur_c,
   output ccr_pkg::nzvc_t        nxt
);
   import ccr_pkg::*;

   always_comb begin
      nxt.n = wf.n;
      nxt.z = wf.z;
      nxt.v = 1'b0;
      nxt.c = cur_c;
      unique case (op)
         OP_ADD: begin
            nxt.c = wf.add_c;
            nxt.v = wf.add_v;
         end
         OP_SUB: begin
            nxt.c = wf.sub_c;
            nxt.v = wf.sub_v;
         end
         OP_TEST: begin
            nxt.v = 1'b0;
            nxt.c = cur_c;
         end
         OP_SHIFT: begin
            nxt.c = shift_c;
            nxt.v = wf.n ^ shift_c;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit #(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        upd_en,
   input  logic [1:0]                  op_class,
   input  logic                        size_wide,
   input  logic [WIDE_W-1:0]           opnd_a,
   input  logic [WIDE_W-1:0]           opnd_b,
   input  logic [WIDE_W-1:0]           result_r,
   input  logic                        shift_c,
   input  logic                        wr_en,
   input  logic [ccr_pkg::SEL_W-1:0]   wr_sel,
   input  logic                        wr_val,
   output logic [ccr_pkg::CCR_W-1:0]   ccr_q
);
   import ccr_pkg::*;

   localparam int N_SIZES = 2;

   generate
      if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_widths
         $error("ccr_flag_unit: NARROW_W must be at least 2 and below WIDE_W");
      end
   endgenerate

   width_flags_t wf_arr [N_SIZES];
   width_flags_t wf_sel;
   nzvc_t        nxt;
   logic [CCR_W-1:0] ccr_d;

   // one flag slice per supported width
   for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_size
      localparam int GW = (gi == 0) ? NARROW_W : WIDE_W;
      ccr_width_flags #(.W(GW)) u_wf (
         .a     (opnd_a[GW-1:0]),
         .b     (opnd_b[GW-1:0]),
         .r     (result_r[GW-1:0]),
         .flags (wf_arr[gi])
      );
   end

   assign wf_sel = size_wide ? wf_arr[1] : wf_arr[0];

   ccr_flag_merge u_merge (
      .op      (ccr_op_e'(op_class)),
      .wf      (wf_sel),
      .shift_c (shift_c),
      .cur_c   (ccr_q[B_C]),
      .nxt     (nxt)
   );

   always_comb begin
      ccr_d = ccr_q;
      if (upd_en) begin
         ccr_d[B_N] = nxt.n;
         ccr_d[B_Z] = nxt.z;
         ccr_d[B_V] = nxt.v;
         ccr_d[B_C] = nxt.c;
      end
      if (wr_en) begin
         ccr_d[wr_sel] = wr_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ccr_q <= CCR_RESET;
      end else begin
         ccr_q <= ccr_d;
      end
   end

endmodule

// File: rtl/ccr_flag_chk.sv
module ccr_flag_chk #(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        upd_en,
   input logic [1:0]                  op_class,
   input logic                        size_wide,
   input logic [WIDE_W-1:0]           opnd_a,
   input logic [WIDE_W-1:0]           opnd_b,
   input logic [WIDE_W-1:0]           result_r,
   input logic                        shift_c,
   input logic                        wr_en,
   input logic [ccr_pkg::SEL_W-1:0]   wr_sel,
   input logic                        wr_val,
   input logic [ccr_pkg::CCR_W-1:0]   ccr_q
);
   import ccr_pkg::*;

   logic r_msb_sel;
   logic r_zero_sel;
   assign r_msb_sel  = size_wide ? result_r[WIDE_W-1] : result_r[NARROW_W-1];
   assign r_zero_sel = size_wide ? (result_r == '0) : (result_r[NARROW_W-1:0] == '0);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !wr_en) |=> $stable(ccr_q));

   p_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en) |=> ccr_q[B_N] == $past(r_msb_sel));

   p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en) |=> ccr_q[B_Z] == $past(r_zero_sel));

   p_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en && op_class == 2'd2) |=>
         (!ccr_q[B_V] && ccr_q[B_C] == $past(ccr_q[B_C])));

   p_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en && op_class == 2'd3) |=>
         (ccr_q[B_C] == $past(shift_c) && ccr_q[B_V] == (ccr_q[B_N] ^ ccr_q[B_C])));

   p_ctrl_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en) |=> ccr_q[7:4] == $past(ccr_q[7:4]));

   p_write_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ccr_q[$past(wr_sel)] == $past(wr_val));

   p_write_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !upd_en) |=>
         ((ccr_q ^ $past(ccr_q)) & ~(CCR_W'(1) << $past(wr_sel))) == '0);

endmodule

bind ccr_flag_unit ccr_flag_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_en    (upd_en),
   .op_class  (op_class),
   .size_wide (size_wide),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .result_r  (result_r),
   .shift_c   (shift_c),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_val    (wr_val),
   .ccr_q     (ccr_q)
);

// File: tb/ccr_flag_unit_tb.sv
`timescale 1ns/1ps
module ccr_flag_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0;
   logic [1:0]  op_class = 2'd0;
   logic        size_wide = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0, result_r = '0;
   logic        shift_c = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic        wr_val = 1'b0;
   logic [7:0]  ccr_q;

   always #2.5 clk = ~clk;

   ccr_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
      .size_wide(size_wide), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result_r(result_r), .shift_c(shift_c), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_val(wr_val), .ccr_q(ccr_q)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t      sb_q[$];
   int         n_vec = 0;
   int         n_bad = 0;
   logic [7:0] model_ccr = 8'hD0;
   bit         finished = 0;

   // independent reference: carries from real arithmetic, r assumed a+b / a-b
   function automatic logic [7:0] model_next(
      input logic [7:0] cur, input logic upd, input logic [1:0] op,
      input logic wide, input logic [15:0] a, input logic [15:0] b,
      input logic [15:0] r, input logic sc, input logic wr,
      input logic [2:0] sel, input logic val);
      logic [7:0]  c;
      logic [15:0] m, aa, bb, rr;
      logic [16:0] sum;
      int          w;
      logic        sa, sb, sr;
      c   = cur;
      w   = wide ? 16 : 8;
      m   = wide ? 16'hFFFF : 16'h00FF;
      aa  = a & m;
      bb  = b & m;
      rr  = r & m;
      sa  = aa[w-1];
      sb  = bb[w-1];
      sr  = rr[w-1];
      sum = {1'b0, aa} + {1'b0, bb};
      if (upd) begin
         c[3] = sr;
         c[2] = (rr == 16'h0);
         case (op)
            2'd0: begin
               c[0] = wide ? sum[16] : sum[8];
               c[1] = (sa == sb) && (sr != sa);
            end
            2'd1: begin
               c[0] = (aa < bb);
               c[1] = (sa != sb) && (sr != sa);
            end
            2'd2: c[1] = 1'b0;
            default: begin
               c[0] = sc;
               c[1] = sr ^ sc;
            end
         endcase
      end
      if (wr) c[sel] = val;
      return c;
   endfunction

   task automatic drive(input logic upd, input logic [1:0] op, input logic wide,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] r, input logic sc, input logic wr,
                        input logic [2:0] sel, input logic val, input string tag);
      item_t it;
      @(negedge clk);
      upd_en = upd; op_class = op; size_wide = wide;
      opnd_a = a; opnd_b = b; result_r = r; shift_c = sc;
      wr_en = wr; wr_sel = sel; wr_val = val;
      model_ccr = model_next(model_ccr, upd, op, wide, a, b, r, sc, wr, sel, val);
      it.exp = model_ccr;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(input string tag);
      drive(1'b0, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 3'd0, 1'b0, tag);
   endtask

   // monitor: compare one expected item per cycle, 1 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (ccr_q !== it.exp) begin
               n_bad++;
               $display("FAIL %s: ccr_q=%02h expected %02h", it.tag, ccr_q, it.exp);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: ccr_q=%02h expected completion", ccr_q);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset value while reset is held
      n_vec++;
      if (ccr_q !== 8'hD0) begin
         n_bad++;
         $display("FAIL R1: ccr_q=%02h expected d0", ccr_q);
      end
      rst_n = 1'b1;
      idle("R1");                       // R1 after release, R2 hold
      idle("R2");
      // R5 R6 R3: 8-bit add 0x7F+0x01, upper bytes carry garbage
      drive(1, 2'd0, 0, 16'hAB7F, 16'h1201, 16'hBD80, 0, 0, 0, 0, "R6");
      // R4 R5: 8-bit add giving zero with carry
      drive(1, 2'd0, 0, 16'h00FF, 16'h0001, 16'h0100, 0, 0, 0, 0, "R4");
      // R5 R6: 16-bit 0x8000+0x8000
      drive(1, 2'd0, 1, 16'h8000, 16'h8000, 16'h0000, 0, 0, 0, 0, "R5");
      // R7: 8-bit 0x00-0x01 borrow
      drive(1, 2'd1, 0, 16'h0000, 16'h0001, 16'hFFFF, 0, 0, 0, 0, "R7");
      // R8: 8-bit 0x80-0x01 overflow
      drive(1, 2'd1, 0, 16'h0080, 16'h0001, 16'h007F, 0, 0, 0, 0, "R8");
      // R8: 16-bit 0x7FFF - 0xFFFF  (positive minus negative)
      drive(1, 2'd1, 1, 16'h7FFF, 16'hFFFF, 16'h8000, 0, 0, 0, 0, "R8");
      // R4: 16-bit equal subtract
      drive(1, 2'd1, 1, 16'h1234, 16'h1234, 16'h0000, 0, 0, 0, 0, "R4");
      // R9: set C directly, then test must keep C and clear V
      drive(0, 2'd0, 0, 0, 0, 0, 0, 1, 3'd0, 1, "R12");
      drive(0, 2'd0, 0, 0, 0, 0, 0, 1, 3'd1, 1, "R12");
      drive(1, 2'd2, 1, 16'h0, 16'h0, 16'h8001, 0, 0, 0, 0, "R9");
      // R3: 16-bit N from bit 15, bit 7 ignored
      drive(1, 2'd2, 1, 16'h0, 16'h0, 16'h0080, 0, 0, 0, 0, "R3");
      // R10: shift with C in
      drive(1, 2'd3, 0, 16'h0, 16'h0, 16'h0080, 1, 0, 0, 0, "R10");
      drive(1, 2'd3, 0, 16'h0, 16'h0, 16'h0001, 1, 0, 0, 0, "R10");
      drive(1, 2'd3, 1, 16'h0, 16'h0, 16'h8000, 0, 0, 0, 0, "R10");
      // R12: writes on control bits
      drive(0, 2'd0, 0, 0, 0, 0, 0, 1, 3'd5, 1, "R12");
      drive(0, 2'd0, 0, 0, 0, 0, 0, 1, 3'd4, 0, "R12");
      drive(0, 2'd0, 0, 0, 0, 0, 0, 1, 3'd7, 0, "R12");
      // R11: update with control bits in a non-reset pattern
      drive(1, 2'd0, 0, 16'h0001, 16'h0001, 16'h0002, 0, 0, 0, 0, "R11");
      // R13: write C=0 while an add produces carry
      drive(1, 2'd0, 0, 16'h00FF, 16'h00FF, 16'h01FE, 0, 1, 3'd0, 0, "R13");
      // R13: write N=0 while shift makes N=1
      drive(1, 2'd3, 0, 16'h0, 16'h0, 16'h00F0, 0, 1, 3'd3, 0, "R13");
      idle("R2");
      // mixed vectors
      for (int i = 0; i < 300; i++) begin
         logic [15:0] a, b, r;
         logic [1:0]  op;
         logic        wide, sc, wr;
         string       tg;
         a    = 16'($urandom);
         b    = 16'($urandom);
         op   = 2'($urandom);
         wide = 1'($urandom);
         sc   = 1'($urandom);
         wr   = ($urandom % 8) == 0;
         r    = (op == 2'd0) ? a + b : (op == 2'd1) ? a - b : 16'($urandom);
         tg   = (op == 2'd0) ? "R5" : (op == 2'd1) ? "R7" : (op == 2'd2) ? "R9" : "R10";
         drive(1'($urandom % 4 != 0), op, wide, a, b, r, sc, wr,
               3'($urandom), 1'($urandom), tg);
      end
      idle("R2");
      idle("R2");
      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule